// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Slave

This block is the slave end of a synchronous serial link that uses a short frame pulse. An external master supplies the serial clock and the frame-sync pulse. The block receives both and moves them into its own faster clock domain through two-flop synchronizers. The serial data input passes through an identical chain, so the data stays aligned with the clock. Every action the block takes comes from edges that it detects after synchronization. A rising edge of frame sync opens a frame. The block then counts both edges of the serial clock and closes the frame on the sixteenth edge, so one frame carries eight data bits.

Local logic preloads a transmit byte with a one-cycle load strobe. When a frame opens, the block takes that byte. It sends the byte MSB first, putting one bit on its serial output at each rising serial-clock edge; there is no start bit. On each falling edge it shifts in one bit from the serial input. When the frame completes, the captured byte appears on a parallel output together with a one-cycle valid pulse. If no byte is waiting when a frame opens, the block sends zeros and raises a one-cycle underrun pulse.

The block adds a fixed latency of a few fast-clock cycles. For that reason, the fast clock must run several times faster than the serial clock. Each phase of the serial clock must last at least four fast-clock cycles.

Top module: `fps_slave`

## Requirements
- R1: After reset, sdo_o is 0, rx_valid_o is 0, underrun_o is 0, tx_empty_o is 1 and rx_data_o is 0.
- R2: A frame opens only on a rising edge of fsync_i. Edges of sclk_i while no frame is open do not change sdo_o, rx_data_o or rx_valid_o.
- R3: A frame closes on the 16th counted sclk_i edge (rising and falling both count), which is the 8th falling edge. At that point rx_valid_o pulses high for exactly one cycle, and rx_data_o then holds the captured byte. The first bit captured is bit 7.
- R4: sdo_o changes only on rising sclk_i edges inside a frame. The first rising edge of the frame presents bit 7 of the transmit byte, with no start bit, and each later rising edge presents the next lower bit.
- R5: sdi_i is sampled on each falling sclk_i edge inside a frame, using the value it had when sclk_i fell.
- R6: A high tx_load_i stores tx_data_i and drives tx_empty_o to 0. Opening a frame consumes the stored byte and returns tx_empty_o to 1.
- R7: If tx_empty_o is 1 when a frame opens, that frame sends 0x00 and underrun_o pulses high for one cycle.
- R8: A rising edge of fsync_i inside an open frame abandons that frame without an rx_valid_o pulse. It restarts the edge count and takes a transmit byte again as in R6/R7.
- R9: All inputs pass a two-flop synchronizer. sdo_o therefore changes on the third rising clk edge after sclk_i rises, and does not change earlier.
- R10: sdo_o returns to 0 when a frame closes and stays at 0 until the first rising sclk_i edge of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the master (asynchronous) |
| fsync_i | input | 1 | Frame-sync pulse from the master (asynchronous) |
| sdi_i | input | 1 | Serial data from the master |
| tx_load_i | input | 1 | Strobe that stores tx_data_i as the next transmit byte |
| tx_data_i | input | 8 | Byte to transmit in the next frame |
| sdo_o | output | 1 | Serial data to the master |
| rx_data_o | output | 8 | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle pulse when a frame completes |
| tx_empty_o | output | 1 | No transmit byte is waiting |
| underrun_o | output | 1 | One-cycle pulse when a frame opens with no byte waiting |

## Verification
The bench sends the 0xC5/0xB5 exchange and several other byte pairs, including all-ones, all-zeros and alternating patterns, which expose a design that shifts in the wrong direction or samples on the wrong edge. A frame that is restarted partway through checks that a design does not raise a valid pulse for the partial frame and does not keep its stale count, which would close the new frame early. Serial-clock edges sent with no frame open would corrupt the received byte in a design that did not gate on the frame. An empty transmit buffer shows whether a design re-sends old data instead of zeros. A cycle-exact probe of the output after a rising serial-clock edge catches an extra or missing synchronizer stage.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int DEF_DATA_W  = 8;
    localparam int DEF_STAGES  = 2;

    // per-input result of the synchronizer / edge detector
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_info_t;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_BUSY = 1'b1
    } fr_state_e;

    // indices into the synchronized input bank
    localparam int SIG_SCLK  = 0;
    localparam int SIG_FSYNC = 1;
    localparam int SIG_SDI   = 2;
    localparam int SIG_COUNT = 3;

    function automatic int edges_per_frame(input int data_w);
        return 2 * data_w;
    endfunction

endpackage

// File: rtl/fps_sync_edge.sv
module fps_sync_edge
    import fps_pkg::*;
#(
    parameter int WIDTH  = SIG_COUNT,
    parameter int STAGES = DEF_STAGES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [WIDTH-1:0]              async_i,
    output edge_info_t [WIDTH-1:0]        ev_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], async_i[g]};
                prev  <= chain[STAGES-1];
            end
        end

        always_comb begin
            ev_o[g].lvl  = chain[STAGES-1];
            ev_o[g].rise = chain[STAGES-1] & ~prev;
            ev_o[g].fall = ~chain[STAGES-1] & prev;
        end
    end

endmodule

// File: rtl/fps_frame_ctl.sv
module fps_frame_ctl
    import fps_pkg::*;
#(
    parameter int EDGES = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fs_rise,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    output logic             active_o,
    output logic [CNT_W-1:0] edge_cnt_o,
    output logic             frame_done_o
);

    fr_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             any_edge;
    logic             last_edge;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

    always_comb begin
        any_edge     = sclk_rise | sclk_fall;
        last_edge    = (cnt == LAST);
        frame_done_o = (state == FR_BUSY) && any_edge && last_edge && !fs_rise;
        active_o     = (state == FR_BUSY);
        edge_cnt_o   = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FR_IDLE;
            cnt   <= '0;
        end else if (fs_rise) begin
            // a new pulse always (re)opens the frame
            state <= FR_BUSY;
            cnt   <= '0;
        end else if (state == FR_BUSY && any_edge) begin
            if (last_edge) begin
                state <= FR_IDLE;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fps_shift_unit.sv
module fps_shift_unit
    import fps_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              frame_done,
    input  logic              sdi_s,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sdo_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              tx_empty_o,
    output logic              underrun_o
);

    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic [DATA_W-1:0] tsr_q;
    logic [DATA_W-1:0] rsr_q;
    logic [DATA_W-1:0] rx_next;

    assign rx_next    = {rsr_q[DATA_W-2:0], sdi_s};
    assign tx_empty_o = ~full_q;

    // transmit holding byte
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (tx_load) begin
            hold_q <= tx_data;
            full_q <= 1'b1;
        end else if (frame_start) begin
            full_q <= 1'b0;
        end
    end

    // transmit path
    always_ff @(posedge clk) begin
        if (rst) begin
            tsr_q      <= '0;
            sdo_o      <= 1'b0;
            underrun_o <= 1'b0;
        end else begin
            underrun_o <= 1'b0;
            if (frame_start) begin
                tsr_q      <= full_q ? hold_q : '0;
                underrun_o <= ~full_q;
                sdo_o      <= 1'b0;
            end else if (frame_done) begin
                sdo_o <= 1'b0;
            end else if (active && sclk_rise) begin
                sdo_o <= tsr_q[DATA_W-1];
                tsr_q <= {tsr_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    // receive path
    always_ff @(posedge clk) begin
        if (rst) begin
            rsr_q      <= '0;
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (frame_start) begin
                rsr_q <= '0;
            end else if (active && sclk_fall) begin
                rsr_q <= rx_next;
                if (frame_done) begin
                    rx_data_o  <= rx_next;
                    rx_valid_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fps_slave.sv
module fps_slave
    import fps_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int STAGES = DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              fsync_i,
    input  logic              sdi_i,
    input  logic              tx_load_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              tx_empty_o,
    output logic              underrun_o
);

    localparam int EDGES = edges_per_frame(DATA_W);
    localparam int CNT_W = $clog2(EDGES + 1);

    edge_info_t [SIG_COUNT-1:0] ev;
    logic [SIG_COUNT-1:0]       raw_in;
    logic                       fs_rise;
    logic                       active;
    logic [CNT_W-1:0]           edge_cnt;
    logic                       frame_done;

    always_comb begin
        raw_in            = '0;
        raw_in[SIG_SCLK]  = sclk_i;
        raw_in[SIG_FSYNC] = fsync_i;
        raw_in[SIG_SDI]   = sdi_i;
    end

    assign fs_rise = ev[SIG_FSYNC].rise;

    fps_sync_edge #(
        .WIDTH (SIG_COUNT),
        .STAGES(STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(raw_in),
        .ev_o   (ev)
    );

    fps_frame_ctl #(
        .EDGES(EDGES),
        .CNT_W(CNT_W)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .fs_rise     (fs_rise),
        .sclk_rise   (ev[SIG_SCLK].rise),
        .sclk_fall   (ev[SIG_SCLK].fall),
        .active_o    (active),
        .edge_cnt_o  (edge_cnt),
        .frame_done_o(frame_done)
    );

    fps_shift_unit #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .frame_start(fs_rise),
        .active     (active),
        .sclk_rise  (ev[SIG_SCLK].rise),
        .sclk_fall  (ev[SIG_SCLK].fall),
        .frame_done (frame_done),
        .sdi_s      (ev[SIG_SDI].lvl),
        .tx_load    (tx_load_i),
        .tx_data    (tx_data_i),
        .sdo_o      (sdo_o),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .tx_empty_o (tx_empty_o),
        .underrun_o (underrun_o)
    );

endmodule

// File: rtl/fps_slave_chk.sv
module fps_slave_chk #(
    parameter int EDGES = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fs_rise,
    input logic             active,
    input logic [CNT_W-1:0] edge_cnt,
    input logic             rx_valid_o,
    input logic             underrun_o,
    input logic             tx_empty_o,
    input logic             tx_load_i,
    input logic             sdo_o
);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> (edge_cnt < CNT_W'(EDGES)));

    assert_valid_at_close_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> ($past(active) && !active));

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        fs_rise |=> (active && edge_cnt == '0));

    assert_underrun_src_R7: assert property (@(posedge clk) disable iff (rst)
        underrun_o |-> ($past(fs_rise) && $past(tx_empty_o)));

    assert_idle_sdo_R10: assert property (@(posedge clk) disable iff (rst)
        (!active && !fs_rise) |=> $stable(sdo_o));

    assert_fill_by_load_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_empty_o) |-> $past(tx_load_i));

endmodule

bind fps_slave fps_slave_chk #(
    .EDGES(EDGES),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fs_rise   (fs_rise),
    .active    (active),
    .edge_cnt  (edge_cnt),
    .rx_valid_o(rx_valid_o),
    .underrun_o(underrun_o),
    .tx_empty_o(tx_empty_o),
    .tx_load_i (tx_load_i),
    .sdo_o     (sdo_o)
);

// File: tb/fps_slave_bench.sv
module fps_slave_bench;

    localparam int HALF = 4;   // fast cycles per serial-clock phase
    localparam int NV   = 7;

    // {preload enable, preload byte, master byte}
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 8'hB5, 8'hC5},
        {1'b1, 8'h5A, 8'hA5},
        {1'b1, 8'hFF, 8'h00},
        {1'b1, 8'h00, 8'hFF},
        {1'b0, 8'h00, 8'h81},
        {1'b1, 8'h01, 8'h80},
        {1'b1, 8'h7E, 8'h3C}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       fsync = 1'b0;
    logic       sdi = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = '0;
    logic       sdo;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       tx_empty;
    logic       underrun;

    int checks = 0;
    int fails  = 0;
    int n_valid = 0;
    int n_under = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst && rx_valid) n_valid++;
        if (!rst && underrun) n_under++;
    end

    fps_slave u_fps_slave (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (sclk),
        .fsync_i   (fsync),
        .sdi_i     (sdi),
        .tx_load_i (tx_load),
        .tx_data_i (tx_data),
        .sdo_o     (sdo),
        .rx_data_o (rx_data),
        .rx_valid_o(rx_valid),
        .tx_empty_o(tx_empty),
        .underrun_o(underrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preload(input logic [7:0] b);
        tx_data = b;
        tx_load = 1'b1;
        wait_n(1);
        tx_load = 1'b0;
    endtask

    task automatic fs_pulse();
        fsync = 1'b1;
        wait_n(HALF);
        fsync = 1'b0;
        wait_n(HALF);
    endtask

    // drive nbits bits of mosi (MSB first) and collect the slave output
    task automatic bits(input logic [7:0] mosi, input int nbits, output logic [7:0] miso);
        miso = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sclk = 1'b1;
            sdi  = mosi[i];
            wait_n(HALF);
            miso[i] = sdo;
            sclk = 1'b0;
            wait_n(HALF);
        end
    endtask

    initial begin : main
        logic [7:0] miso;
        int v0, u0;

        wait_n(4);
        // R1: reset state
        chk("R1 sdo", sdo, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 underrun", underrun, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_data", rx_data, 0);
        rst = 1'b0;
        wait_n(4);

        // vector table: R3 R4 R5 R6 R7 R10
        for (int k = 0; k < NV; k++) begin
            v0 = n_valid;
            u0 = n_under;
            if (VEC[k][16]) begin
                preload(VEC[k][15:8]);
                chk("R6 tx_empty after load", tx_empty, 0);
            end
            fs_pulse();
            chk("R6 tx_empty after frame open", tx_empty, 1);
            bits(VEC[k][7:0], 8, miso);
            wait_n(6);
            chk("R4 slave-to-master byte", miso, VEC[k][16] ? VEC[k][15:8] : 8'h00);
            chk("R5 R3 captured byte", rx_data, VEC[k][7:0]);
            chk("R3 one valid pulse", n_valid - v0, 1);
            chk("R7 underrun pulses", n_under - u0, VEC[k][16] ? 0 : 1);
            chk("R10 sdo idle after frame", sdo, 0);
        end

        // R2: serial clock with no frame open is ignored
        v0 = n_valid;
        for (int i = 0; i < 6; i++) begin
            sdi = 1'b1;
            sclk = 1'b1; wait_n(HALF);
            sclk = 1'b0; wait_n(HALF);
        end
        wait_n(6);
        chk("R2 no valid outside frame", n_valid - v0, 0);
        chk("R2 rx_data kept", rx_data, 8'h3C);
        chk("R2 sdo kept", sdo, 0);

        // R9: output timing after a rising serial-clock edge
        preload(8'h80);
        fs_pulse();
        sclk = 1'b1;
        sdi = 1'b0;
        wait_n(2);
        chk("R9 sdo not yet changed", sdo, 0);
        wait_n(1);
        chk("R9 sdo changed on third edge", sdo, 1);
        wait_n(HALF - 3);
        sclk = 1'b0;
        wait_n(HALF);
        bits(8'h00, 7, miso);
        wait_n(6);
        chk("R3 frame after timing probe", rx_data, 8'h00);

        // R8: abandoned frame
        v0 = n_valid;
        u0 = n_under;
        preload(8'h11);
        fs_pulse();
        bits(8'hFF, 3, miso);
        wait_n(6);
        chk("R8 no valid for partial frame", n_valid - v0, 0);
        preload(8'h3C);
        fs_pulse();
        bits(8'h96, 8, miso);
        wait_n(6);
        chk("R8 restarted frame byte out", miso, 8'h3C);
        chk("R8 restarted frame byte in", rx_data, 8'h96);
        chk("R8 single valid", n_valid - v0, 1);
        chk("R8 no underrun", n_under - u0, 0);

        // R8 R7: restart with nothing preloaded sends zeros
        u0 = n_under;
        preload(8'hA5);
        fs_pulse();
        bits(8'h00, 2, miso);
        fs_pulse();
        bits(8'h5B, 8, miso);
        wait_n(6);
        chk("R7 restart without preload sends zeros", miso, 8'h00);
        chk("R7 underrun on restart", n_under - u0, 1);
        chk("R8 byte after empty restart", rx_data, 8'h5B);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule